// File: doc/BRIEF.md
# Software Standby Entry and Wake Controller

This block moves a chip between normal running and a software standby state. Software writes a two-bit control register that holds a standby-enable bit and a deep-mode bit. It then raises a one-cycle sleep strobe. The block enters standby only when that strobe arrives with standby-enable set and deep-mode clear. In standby it gates off the CPU clock, the peripheral clock and the oscillator. Depending on the clock mode, it can also gate the external clock output.

While in standby the block watches one non-maskable interrupt pin and eight IRQ pins. Each pin has its own edge selection. A qualifying edge restarts the oscillator, but only a settling counter is clocked at first. That counter is an 8-bit up-counter behind a prescaler, and its ratio comes from a 3-bit select. All other clocks come back only when the counter overflows. A manual reset or a power-on reset leaves standby at once, with no settling wait, and clears the control register.

Top module: `standby_ctrl`

## Requirements
- R1: Standby is entered on a `sleepStrobe` cycle in run only when the committed register has bit 1 (standby-enable) = 1 and bit 0 (deep) = 0. The values 00, 01 and 11 leave the block running.
- R2: In run, `cpuClkEn`, `periClkEn` and `oscEn` are 1. In standby all three are 0 and `inStandby` is 1.
- R3: When `clkMode` is 0 or 2, `extClkEn` is 0 during standby and settling and returns to 1 in run. When `clkMode` is 1 or 3, `extClkEn` stays 1 throughout.
- R4: In standby, `nmiPin` wakes the block on a rising edge when `nmiRiseSel` = 1 and on a falling edge when it is 0. The opposite edge has no effect.
- R5: IRQ line i uses `irqSense[2i+1:2i]` to choose its wake edge: 00 = never wakes, 01 = falling, 10 = rising, 11 = either edge.
- R6: After a wake edge, only `settleClkEn` and `oscEn` are 1, for exactly 256×D cycles. D is 1, 4, 16, 32, 64, 256, 1024 or 4096 for `settleSel` = 0..7. The block then returns to run.
- R7: A register write is committed on the second rising edge after the write cycle. `regRdData` always shows the committed value, and the sleep decision uses that committed value.
- R8: `mresetN` low at a rising edge forces run on that edge, with no settling period, and clears the register to 00.
- R9: `porN` low asynchronously forces run and clears the register to 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| porN | input | 1 | Power-on reset, active low, asynchronous |
| mresetN | input | 1 | Manual reset, active low, synchronous |
| sleepStrobe | input | 1 | One-cycle sleep request |
| regWrEn | input | 1 | Control register write enable |
| regWrData | input | 2 | Write data: bit 1 standby-enable, bit 0 deep |
| regRdData | output | 2 | Committed control register value |
| clkMode | input | 2 | Clock mode; 0 and 2 halt the external clock in standby |
| settleSel | input | 3 | Settling prescale select |
| nmiPin | input | 1 | Non-maskable interrupt pin |
| nmiRiseSel | input | 1 | 1 = NMI wakes on rising edge, 0 = falling |
| irqPins | input | 8 | IRQ pins |
| irqSense | input | 16 | Two sense bits per IRQ line |
| cpuClkEn | output | 1 | CPU clock enable |
| periClkEn | output | 1 | Peripheral clock enable |
| extClkEn | output | 1 | External clock output enable |
| oscEn | output | 1 | Oscillator enable |
| settleClkEn | output | 1 | Settling counter clock enable |
| inStandby | output | 1 | High while in standby |

## Verification
A wrong state or counter value in this block shows up as clock enables with the wrong level or the wrong timing. If the state register lands in standby without a qualifying request, the clock enables drop within one cycle. A wake on a wrong or ignored edge shows up as `settleClkEn` rising on the cycle after that edge. A miscounted prescaler or counter changes the length of the `settleClkEn` pulse, and the bench measures that length exactly against 256×D. A register commit that is too early or too late shows in `regRdData` on the first or second cycle after the write.

// File: rtl/stby_pkg.sv
package stby_pkg;
  typedef enum logic [1:0] {
    ST_RUN    = 2'd0,
    ST_STBY   = 2'd1,
    ST_SETTLE = 2'd2
  } stbyState_e;

  typedef struct packed {
    logic clrCnt;
    logic runCnt;
  } ctlStrobe_t;
endpackage

// File: rtl/stby_dp.sv
module stby_dp
  import stby_pkg::*;
#(
  parameter int IRQ_N = 8,
  parameter int CNT_W = 8,
  parameter int PRE_W = 12
) (
  input  logic               clk,
  input  logic               porN,
  input  logic               mrst,
  input  logic               regWrEn,
  input  logic [1:0]         regWrData,
  output logic [1:0]         regRdData,
  input  logic               nmiPin,
  input  logic               nmiRiseSel,
  input  logic [IRQ_N-1:0]   irqPins,
  input  logic [2*IRQ_N-1:0] irqSense,
  input  logic [2:0]         settleSel,
  input  ctlStrobe_t         strobe,
  output logic               wakeHit,
  output logic               settleDone,
  output logic               stbyArm
);
  localparam int SH_W = $clog2(PRE_W + 1);

  // control register: write lands in a pending stage, commits one edge later
  logic [1:0] pendReg, commitReg;
  logic       pendValid;

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      pendReg   <= '0;
      pendValid <= 1'b0;
      commitReg <= '0;
    end else if (mrst) begin
      pendReg   <= '0;
      pendValid <= 1'b0;
      commitReg <= '0;
    end else begin
      pendValid <= regWrEn;
      if (regWrEn) pendReg <= regWrData;
      if (pendValid) commitReg <= pendReg;
    end
  end

  assign regRdData = commitReg;
  assign stbyArm   = commitReg[1] & ~commitReg[0];

  // edge detection
  logic             nmiPrev;
  logic [IRQ_N-1:0] irqPrev;
  logic [IRQ_N-1:0] irqHit;
  logic             nmiEdge;

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      nmiPrev <= 1'b0;
      irqPrev <= '0;
    end else begin
      nmiPrev <= nmiPin;
      irqPrev <= irqPins;
    end
  end

  assign nmiEdge = nmiRiseSel ? (nmiPin & ~nmiPrev) : (~nmiPin & nmiPrev);

  for (genvar i = 0; i < IRQ_N; i++) begin : g_irq
    logic rise, fall;
    assign rise      = irqPins[i] & ~irqPrev[i];
    assign fall      = ~irqPins[i] & irqPrev[i];
    assign irqHit[i] = (irqSense[2*i+1] & rise) | (irqSense[2*i] & fall);
  end

  assign wakeHit = nmiEdge | (|irqHit);

  // settling prescaler and counter
  function automatic logic [PRE_W-1:0] preLimit(input logic [2:0] sel);
    logic [SH_W-1:0] sh;
    case (sel)
      3'd0:    sh = SH_W'(0);
      3'd1:    sh = SH_W'(2);
      3'd2:    sh = SH_W'(4);
      3'd3:    sh = SH_W'(5);
      3'd4:    sh = SH_W'(6);
      3'd5:    sh = SH_W'(8);
      3'd6:    sh = SH_W'(10);
      default: sh = SH_W'(12);
    endcase
    return (PRE_W'(1) << sh) - PRE_W'(1);
  endfunction

  logic [PRE_W-1:0] preCnt;
  logic [CNT_W-1:0] settleCnt;
  logic             preTick;

  assign preTick = (preCnt == preLimit(settleSel));

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      preCnt    <= '0;
      settleCnt <= '0;
    end else if (strobe.clrCnt) begin
      preCnt    <= '0;
      settleCnt <= '0;
    end else if (strobe.runCnt) begin
      preCnt <= preTick ? '0 : preCnt + PRE_W'(1);
      if (preTick) settleCnt <= settleCnt + CNT_W'(1);
    end
  end

  assign settleDone = strobe.runCnt & preTick & (&settleCnt);

  p_cnt_start_r6: assert property (@(posedge clk) disable iff (!porN)
    $past(strobe.clrCnt) |-> (settleCnt == '0 && preCnt == '0));

  p_reset_clear_r8: assert property (@(posedge clk) disable iff (!porN)
    $past(mrst) |-> (regRdData == 2'b00));
endmodule

// File: rtl/stby_ctl.sv
module stby_ctl
  import stby_pkg::*;
(
  input  logic       clk,
  input  logic       porN,
  input  logic       mrst,
  input  logic       sleepStrobe,
  input  logic       stbyArm,
  input  logic       wakeHit,
  input  logic       settleDone,
  input  logic [1:0] clkMode,
  output ctlStrobe_t strobe,
  output logic       cpuClkEn,
  output logic       periClkEn,
  output logic       extClkEn,
  output logic       oscEn,
  output logic       settleClkEn,
  output logic       inStandby
);
  stbyState_e state, stateNext;

  always_comb begin
    stateNext = state;
    case (state)
      ST_RUN:    if (sleepStrobe && stbyArm) stateNext = ST_STBY;
      ST_STBY:   if (wakeHit) stateNext = ST_SETTLE;
      ST_SETTLE: if (settleDone) stateNext = ST_RUN;
      default:   stateNext = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge porN) begin
    if (!porN)     state <= ST_RUN;
    else if (mrst) state <= ST_RUN;
    else           state <= stateNext;
  end

  assign strobe.clrCnt = (state == ST_STBY) && wakeHit;
  assign strobe.runCnt = (state == ST_SETTLE);

  logic extHalts;
  assign extHalts    = (clkMode == 2'd0) || (clkMode == 2'd2);
  assign cpuClkEn    = (state == ST_RUN);
  assign periClkEn   = (state == ST_RUN);
  assign oscEn       = (state != ST_STBY);
  assign settleClkEn = (state == ST_SETTLE);
  assign inStandby   = (state == ST_STBY);
  assign extClkEn    = (state == ST_RUN) || !extHalts;

  p_entry_qual_r1: assert property (@(posedge clk) disable iff (!porN || mrst)
    (state == ST_RUN && !(sleepStrobe && stbyArm)) |=> (state == ST_RUN));

  p_stby_hold_r5: assert property (@(posedge clk) disable iff (!porN || mrst)
    (state == ST_STBY && !wakeHit) |=> (state == ST_STBY));

  p_no_skip_settle_r6: assert property (@(posedge clk) disable iff (!porN || mrst)
    (state == ST_STBY) |=> (state != ST_RUN));

  p_settle_hold_r6: assert property (@(posedge clk) disable iff (!porN || mrst)
    (state == ST_SETTLE && !settleDone) |=> (state == ST_SETTLE));

  p_gate_order_r2: assert property (@(posedge clk) disable iff (!porN)
    cpuClkEn |-> (oscEn && periClkEn && !settleClkEn));
endmodule

// File: rtl/standby_ctrl.sv
module standby_ctrl
  import stby_pkg::*;
(
  input  logic        clk,
  input  logic        porN,
  input  logic        mresetN,
  input  logic        sleepStrobe,
  input  logic        regWrEn,
  input  logic [1:0]  regWrData,
  output logic [1:0]  regRdData,
  input  logic [1:0]  clkMode,
  input  logic [2:0]  settleSel,
  input  logic        nmiPin,
  input  logic        nmiRiseSel,
  input  logic [7:0]  irqPins,
  input  logic [15:0] irqSense,
  output logic        cpuClkEn,
  output logic        periClkEn,
  output logic        extClkEn,
  output logic        oscEn,
  output logic        settleClkEn,
  output logic        inStandby
);
  ctlStrobe_t strobe;
  logic wakeHit, settleDone, stbyArm, mrst;

  assign mrst = ~mresetN;

  stby_dp #(.IRQ_N(8), .CNT_W(8), .PRE_W(12)) u_dp (
    .clk(clk), .porN(porN), .mrst(mrst),
    .regWrEn(regWrEn), .regWrData(regWrData), .regRdData(regRdData),
    .nmiPin(nmiPin), .nmiRiseSel(nmiRiseSel),
    .irqPins(irqPins), .irqSense(irqSense), .settleSel(settleSel),
    .strobe(strobe), .wakeHit(wakeHit), .settleDone(settleDone), .stbyArm(stbyArm)
  );

  stby_ctl u_ctl (
    .clk(clk), .porN(porN), .mrst(mrst),
    .sleepStrobe(sleepStrobe), .stbyArm(stbyArm), .wakeHit(wakeHit),
    .settleDone(settleDone), .clkMode(clkMode), .strobe(strobe),
    .cpuClkEn(cpuClkEn), .periClkEn(periClkEn), .extClkEn(extClkEn),
    .oscEn(oscEn), .settleClkEn(settleClkEn), .inStandby(inStandby)
  );
endmodule

// File: tb/sim_standby_ctrl.sv
module sim_standby_ctrl;
  localparam int CLK_P = 10;

  logic clk = 1'b0;
  logic porN = 1'b0, mresetN = 1'b1, sleepStrobe = 1'b0, regWrEn = 1'b0;
  logic [1:0] regWrData = '0, clkMode = '0;
  logic [2:0] settleSel = '0;
  logic nmiPin = 1'b0, nmiRiseSel = 1'b0;
  logic [7:0] irqPins = '0;
  logic [15:0] irqSense = '0;
  logic [1:0] regRdData;
  logic cpuClkEn, periClkEn, extClkEn, oscEn, settleClkEn, inStandby;

  int total = 0, bad = 0, runLen = 0;
  int expQ[$];
  bit finished = 0;

  always #(CLK_P/2) clk = ~clk;

  standby_ctrl u0 (.*);

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // monitor: measures each settling window and compares with the scoreboard
  always @(negedge clk) begin
    if (settleClkEn) runLen++;
    else if (runLen > 0) begin
      if (expQ.size() == 0) chk("R6 unexpected settle", runLen, 0);
      else chk("R6 settle length", runLen, expQ.pop_front());
      runLen = 0;
    end
  end

  task automatic wrReg(input logic [1:0] v);
    @(negedge clk); regWrEn = 1'b1; regWrData = v;
    @(negedge clk); regWrEn = 1'b0;
    @(negedge clk);
  endtask

  task automatic sleepReq();
    @(negedge clk); sleepStrobe = 1'b1;
    @(negedge clk); sleepStrobe = 1'b0;
  endtask

  task automatic waitRun();
    for (int i = 0; i < 20000 && !cpuClkEn; i++) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic wake(input int sel);
    // driver: pushes the expected settling length before the wake edge lands
    int d;
    case (sel)
      0: d = 1; 1: d = 4; 2: d = 16; 3: d = 32;
      4: d = 64; 5: d = 256; 6: d = 1024; default: d = 4096;
    endcase
    expQ.push_back(256 * d);
  endtask

  initial begin
    #(CLK_P * 200000);
    bad++; total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_P * 2 + 1); porN = 1'b1;
    @(negedge clk);
    chk("R9 reset cpuClkEn", cpuClkEn, 1);
    chk("R9 reset reg", regRdData, 0);
    chk("R3 reset extClkEn", extClkEn, 1);

    // R7 commit latency
    @(negedge clk); regWrEn = 1'b1; regWrData = 2'b11;
    @(negedge clk); regWrEn = 1'b0;
    chk("R7 not yet committed", regRdData, 0);
    @(negedge clk);
    chk("R7 committed", regRdData, 3);
    sleepReq();
    chk("R1 deep set stays run", inStandby, 0);
    wrReg(2'b00); sleepReq();
    chk("R1 standby clear stays run", inStandby, 0);
    wrReg(2'b01); sleepReq();
    chk("R1 deep only stays run", cpuClkEn, 1);

    // enter, NMI falling wake, mode 0
    wrReg(2'b10); clkMode = 2'd0; settleSel = 3'd0; nmiRiseSel = 1'b0;
    sleepReq();
    chk("R1 entered", inStandby, 1);
    chk("R2 cpu off", cpuClkEn, 0);
    chk("R2 peri off", periClkEn, 0);
    chk("R2 osc off", oscEn, 0);
    chk("R3 mode0 ext off", extClkEn, 0);
    nmiPin = 1'b1; @(negedge clk); @(negedge clk);
    chk("R4 wrong NMI edge ignored", inStandby, 1);
    wake(0); nmiPin = 1'b0; @(negedge clk);
    chk("R6 settle clk on", settleClkEn, 1);
    chk("R6 osc on", oscEn, 1);
    chk("R6 cpu still off", cpuClkEn, 0);
    chk("R3 mode0 ext off in settle", extClkEn, 0);
    waitRun();
    chk("R6 back to run", cpuClkEn, 1);
    chk("R3 ext resumes", extClkEn, 1);

    // mode 1, IRQ3 sense 00 ignored then falling wake
    clkMode = 2'd1; settleSel = 3'd1; irqSense = '0;
    sleepReq();
    chk("R3 mode1 ext kept", extClkEn, 1);
    irqPins[3] = 1'b1; @(negedge clk); irqPins[3] = 1'b0; @(negedge clk); @(negedge clk);
    chk("R5 sense 00 ignored", inStandby, 1);
    irqSense[7:6] = 2'b01; irqPins[3] = 1'b1; @(negedge clk); @(negedge clk);
    chk("R5 rising ignored by falling sense", inStandby, 1);
    wake(1); irqPins[3] = 1'b0; @(negedge clk);
    chk("R5 IRQ3 falling wake", settleClkEn, 1);
    waitRun();

    // IRQ5 rising, prescale 16
    irqSense = '0; irqSense[11:10] = 2'b10; settleSel = 3'd2;
    sleepReq();
    wake(2); irqPins[5] = 1'b1; @(negedge clk);
    chk("R5 IRQ5 rising wake", settleClkEn, 1);
    waitRun();

    // IRQ0 both edges, NMI rising
    irqSense = '0; irqSense[1:0] = 2'b11; settleSel = 3'd0;
    irqPins[0] = 1'b1; @(negedge clk);
    sleepReq();
    wake(0); irqPins[0] = 1'b0; @(negedge clk);
    chk("R5 IRQ0 both-edge wake", settleClkEn, 1);
    waitRun();
    irqSense = '0; nmiRiseSel = 1'b1;
    sleepReq();
    wake(0); nmiPin = 1'b1; @(negedge clk);
    chk("R4 NMI rising wake", settleClkEn, 1);
    waitRun();

    // R8 manual reset out of standby
    sleepReq();
    chk("R8 in standby before reset", inStandby, 1);
    mresetN = 1'b0; @(negedge clk); mresetN = 1'b1;
    chk("R8 run at once", cpuClkEn, 1);
    chk("R8 no settle", settleClkEn, 0);
    chk("R8 reg cleared", regRdData, 0);

    // R9 power-on reset out of standby
    wrReg(2'b10); sleepReq();
    #2 porN = 1'b0; #1;
    chk("R9 async run", cpuClkEn, 1);
    chk("R9 reg cleared", regRdData, 0);
    @(negedge clk); porN = 1'b1;
    repeat (3) @(negedge clk);

    chk("R6 scoreboard drained", expQ.size(), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule